// File: doc/BRIEF.md
# Fractional Global Pacing Timer

This block sets the overall pace at which a cell-based network adapter may fetch batches of cells across its host bus. A prescaler divides the bus clock by a fixed period of 14 cycles and marks each end of period with a one-cycle wake strobe. At every wake, a 16.8 fixed-point accumulator gains 1.0 (256) and is compared against a programmable 24-bit pacing parameter. When the accumulator reaches the parameter, the block emits a one-cycle pacing tick and subtracts the parameter, keeping the remainder. The parameter therefore sets a period counted in wake-ups, with a fractional part, and the long-run rate is exact.

Each tick allows one batch of cells to be transferred, whatever the class of the transmit channel. The batch size is held elsewhere. Computing the parameter, estimating the bus clock rate and moving the data are all outside this block. For example, a parameter of 0x80D (about 8.05 wake-ups) gives roughly one batch every 112 bus clocks.

A two-state control machine gates the timer. `PS_IDLE` is entered from reset, and again whenever `en_i` is low. While in `PS_IDLE`, the prescaler and accumulator are held at zero. The machine moves from `PS_IDLE` to `PS_RUN` on the first edge at which `en_i` is high. It moves from `PS_RUN` back to `PS_IDLE` on any edge at which `en_i` is low. The prescaler advances only in `PS_RUN` while `en_i` stays high.

Top module: `batch_pace_timer`

## Requirements
- R1: `wake_o` is a single-cycle strobe repeating every 14 clock cycles while enabled. The first `wake_o` appears 15 rising edges after `en_i` is first sampled high: one edge to enter `PS_RUN` plus 14 edges of counting.
- R2: Each wake adds 256 to the accumulator. When the sum is at least the effective parameter, a tick is emitted and the parameter is subtracted, keeping the remainder. Starting from a cleared accumulator, the number of ticks after W wakes is floor(256*W / effective parameter).
- R3: `tick_o` is high only in a cycle where `wake_o` is also high, so there is at most one tick per wake.
- R4: A parameter below 256 (0x000 to 0x0FF) is treated as 256, which gives a tick on every wake.
- R5: The parameter is sampled only at a wake. A change made between two wakes first affects the decision at the next wake and causes no tick before it.
- R6: While `en_i` is low, `wake_o` and `tick_o` stay low and the prescaler and accumulator are cleared. After re-enabling, the timer starts fresh with no carried remainder.
- R7: Reset (`rst_n` low, asynchronous) drives `wake_o` and `tick_o` low and clears all state. After release with `en_i` high, timing restarts exactly as in R1.
- R8: With parameter 0x80D, the first tick comes on the 9th wake, and 100 wakes give 12 ticks.
- R9: The control machine follows the `PS_IDLE` / `PS_RUN` transitions described above. In `PS_IDLE`, no wake or tick is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Timer enable; low holds all state at zero |
| pace_param_i | input | 24 | Global pacing parameter, 16 integer and 8 fraction bits, counted in wake-ups |
| wake_o | output | 1 | One-cycle strobe at each 14-cycle wake-up |
| tick_o | output | 1 | One-cycle global pacing tick granting one batch |

## Verification
The assertions assume that `en_i` and `pace_param_i` are synchronous to `clk` and settle before each rising edge. They also assume the wake period is longer than one cycle, so that two strobes can never touch. The bench changes every input on the falling edge and samples the outputs there too. Through a table it holds each parameter steady across a whole run of wakes, and it changes the parameter only between two wakes when testing the deferred-update rule.

// File: rtl/pace_pkg.sv
package pace_pkg;

    // Control machine states for the pacing timer.
    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_RUN  = 1'b1
    } pace_state_e;

    // Raise a fixed-point parameter to at least one whole wake-up.
    function automatic logic [23:0] pace_floor_one(input logic [23:0] p, input logic [23:0] one);
        return (p < one) ? one : p;
    endfunction

endpackage

// File: rtl/pace_ctrl.sv
module pace_ctrl
    import pace_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    output logic        run_o,
    output logic        clr_o,
    output pace_state_e state_o
);

    pace_state_e state_q;
    pace_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (en_i)  state_d = PS_RUN;
            PS_RUN:  if (!en_i) state_d = PS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        run_o = 1'b0;
        clr_o = !en_i;
        unique case (state_q)
            PS_IDLE: run_o = 1'b0;
            PS_RUN:  run_o = en_i;
        endcase
    end

    assign state_o = state_q;

    // R9: leaving enable always lands in idle on the next edge
    p_drop_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == PS_IDLE);

endmodule

// File: rtl/pace_prescaler.sv
module pace_prescaler #(
    parameter int PERIOD = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic due_o,
    output logic wake_o
);

    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign due_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wake_o <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            wake_o <= 1'b0;
        end else begin
            wake_o <= due_o;
            if (run_i) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // R1: counter stays within one period
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R1: a wake strobe lasts a single cycle
    p_wake_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R6: clearing empties the counter and silences the strobe
    p_clr_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0) && !wake_o);

endmodule

// File: rtl/pace_accum.sv
module pace_accum
    import pace_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    due_i,
    input  logic [INT_W+FRAC_W-1:0] param_i,
    output logic                    tick_o
);

    localparam int PW = INT_W + FRAC_W;
    localparam logic [PW-1:0] ONE = PW'(1) << FRAC_W;

    logic [PW-1:0] acc_q;
    logic [PW-1:0] eff;
    logic [PW:0]   sum;
    logic          hit;

    always_comb begin
        eff = pace_floor_one(param_i, ONE);
        sum = {1'b0, acc_q} + {1'b0, ONE};
        hit = (sum >= {1'b0, eff});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (clr_i) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (due_i) begin
            tick_o <= hit;
            acc_q  <= hit ? PW'(sum - {1'b0, eff}) : sum[PW-1:0];
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R6: accumulator is empty after a clear
    p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_q == '0);

    // R3: ticks never come back to back
    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R4: a sub-unity parameter fires on every wake
    p_clamp_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (due_i && !clr_i && (param_i < ONE)) |=> tick_o);

endmodule

// File: rtl/batch_pace_timer.sv
module batch_pace_timer
    import pace_pkg::*;
#(
    parameter int WAKE_PERIOD = 14,
    parameter int INT_W       = 16,
    parameter int FRAC_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [INT_W+FRAC_W-1:0] pace_param_i,
    output logic                    wake_o,
    output logic                    tick_o
);

    logic        run;
    logic        clr;
    logic        due;
    pace_state_e state;

    pace_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .run_o   (run),
        .clr_o   (clr),
        .state_o (state)
    );

    pace_prescaler #(
        .PERIOD (WAKE_PERIOD)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .run_i  (run),
        .due_o  (due),
        .wake_o (wake_o)
    );

    pace_accum #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .due_i   (due),
        .param_i (pace_param_i),
        .tick_o  (tick_o)
    );

    // R3: a tick only rides on a wake strobe
    p_tick_on_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> wake_o);

    // R9: idle state carries no strobes
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE) |-> (!wake_o && !tick_o));

endmodule

// File: tb/tb_batch_pace_timer.sv
module tb_batch_pace_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [23:0] pace_param_i = 24'h0;
    logic        wake_o;
    logic        tick_o;

    int total = 0;
    int bad = 0;
    int stray = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    batch_pace_timer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .pace_param_i (pace_param_i),
        .wake_o       (wake_o),
        .tick_o       (tick_o)
    );

    // Vector table: parameter, wakes to run, expected ticks (R2/R4/R8)
    localparam int NV = 9;
    localparam logic [23:0] VP [NV] = '{24'h00080D, 24'h000000, 24'h0000FF, 24'h000100,
                                        24'h000180, 24'h000200, 24'h000101, 24'h000A00,
                                        24'hFFFFFF};
    localparam int VW [NV] = '{100, 20, 20, 20, 30, 31, 300, 55, 100};
    localparam int VT [NV] = '{12, 20, 20, 20, 20, 15, 298, 5, 0};

    always @(negedge clk) if (tick_o && !wake_o) stray++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic [23:0] p);
        @(negedge clk) en_i = 1'b0;
        repeat (2) @(negedge clk);
        pace_param_i = p;
        en_i = 1'b1;
    endtask

    task automatic next_wake(output bit tk, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!wake_o);
        tk = tick_o;
    endtask

    task automatic run_wakes(input int w, output int ticks);
        bit tk;
        int g;
        ticks = 0;
        for (int k = 0; k < w; k++) begin
            next_wake(tk, g);
            if (tk) ticks++;
        end
    endtask

    initial begin
        int t;
        int g;
        bit tk;
        int first;

        // R7: reset state
        repeat (3) @(negedge clk);
        check(!wake_o && !tick_o, "R7 reset outputs", {wake_o, tick_o}, 0);
        rst_n = 1'b1;

        // Table of vectors (R2, R4, R8)
        for (int i = 0; i < NV; i++) begin
            restart(VP[i]);
            run_wakes(VW[i], t);
            check(t == VT[i], "R2 tick count per vector", t, VT[i]);
        end

        // R1: first wake delay and period
        restart(24'h000100);
        next_wake(tk, g);
        check(g == 15, "R1 first wake delay", g, 15);
        next_wake(tk, g);
        check(g == 14, "R1 wake period", g, 14);
        check(tk == 1'b1, "R4 param 0x100 ticks each wake", tk, 1);

        // R8: first tick of 0x80D on wake 9
        restart(24'h00080D);
        first = 0;
        for (int k = 1; k <= 12; k++) begin
            next_wake(tk, g);
            if (tk && first == 0) first = k;
        end
        check(first == 9, "R8 first tick wake index", first, 9);

        // R5: parameter change between wakes applies at next wake
        restart(24'h000100);
        run_wakes(3, t);
        check(t == 3, "R5 pre-change ticks", t, 3);
        @(negedge clk) pace_param_i = 24'h000300;
        next_wake(tk, g);
        check(tk == 1'b0, "R5 wake 1 after change", tk, 0);
        next_wake(tk, g);
        check(tk == 1'b0, "R5 wake 2 after change", tk, 0);
        next_wake(tk, g);
        check(tk == 1'b1, "R5 wake 3 after change", tk, 1);

        // R6: disable mid-run clears the remainder and silences outputs
        restart(24'h000300);
        run_wakes(2, t);
        check(t == 0, "R6 partial accumulate", t, 0);
        @(negedge clk) en_i = 1'b0;
        t = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (wake_o || tick_o) t++;
        end
        check(t == 0, "R6 quiet while disabled", t, 0);
        en_i = 1'b1;
        next_wake(tk, g);
        check(g == 15 && !tk, "R6 fresh restart wake 1", g, 15);
        next_wake(tk, g);
        check(tk == 1'b0, "R6 fresh restart wake 2", tk, 0);
        next_wake(tk, g);
        check(tk == 1'b1, "R6 fresh restart wake 3", tk, 1);

        // R7: reset mid-run
        restart(24'h000100);
        run_wakes(2, t);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!wake_o && !tick_o, "R7 outputs in reset", {wake_o, tick_o}, 0);
        rst_n = 1'b1;
        next_wake(tk, g);
        check(g == 15, "R7 first wake after reset", g, 15);

        // R3: no tick ever seen without a wake
        check(stray == 0, "R3 stray ticks", stray, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule